// File: doc/BRIEF.md
# Fan Tachometer Period Counter

This block measures how long a fan takes to turn once. A reference tick of about 90 kHz comes from a divider on the system clock. A counter adds one for each tick between two rising edges of the fan sense input, and that input pulses once per revolution. On each rising edge the running count moves into a result register and counting starts again from zero. If no edge arrives before the counter reaches its largest value, the counter stops there and the result reports that value at once. This means the fan has stalled or is turning too slowly.

A host reads the result over a simple byte-wide bus through two ports at a programmable 16-bit base address. Offset 0 is an index register. Offset 1 is a data port that reads or writes the register the index selects. The 16-bit result is split into a low byte register and a high byte register. Reading the low byte copies the high byte into a holding register, and a later read of the high byte returns the held copy. So a host that reads low then high always gets two halves of the same sample.

The measurement logic is a two-state machine. In `MEAS_RUN` the counter advances on each tick. The transition run-to-stall is taken when the next count would reach the maximum and no edge is present. In `MEAS_STALL` the count and the result stay at the maximum. The transition stall-to-run is taken on the next revolution edge.

Top module: `tach_monitor`

## Requirements
- R1: After reset, the result and the holding register are zero and the index register is 0x00. Reads of the low byte (index 0x10), the high byte (index 0x11) and the index port all return 0x00.
- R2: The counter advances once every TICK_DIV clock cycles. A fan input whose rising edges are P cycles apart, with P a multiple of TICK_DIV, gives a steady result of P/TICK_DIV.
- R3: Each rising edge of the fan input, after a two-flop synchroniser, captures the running count into the result and restarts the count from zero. A new period therefore replaces the old value and does not add to it.
- R4: When the count reaches 2^CNT_W-1 (0xFFFF by default) without an edge, the result becomes that value and holds it until the next edge. After that edge, measurement resumes normally.
- R5: A write to offset 0 loads the index register, and a read of offset 0 returns it. Read data appears on bus_rdata in the cycle after the read strobe and is 0x00 in every other cycle.
- R6: A read of index 0x10 returns result bits 7:0 and copies result bits 15:8 into the holding register.
- R7: A read of index 0x11 returns the holding register. This is true even if the result has changed since the last low byte read, and even if no low byte read came before it.
- R8: Reads of unimplemented index values return 0x00. Writes to index 0x10 and index 0x11 have no effect.
- R9: The base address resets to 0x0480. Index 0x30 holds its high byte and index 0x31 its low byte, and both can be read and written. Bus accesses outside base and base+1 are ignored, and their reads return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tach_in | input | 1 | Fan sense input, one rising edge per revolution, asynchronous |
| bus_addr | input | 16 | Host byte address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd, otherwise 0x00 |

## Verification
The assertions assume that the fan input stays high and low for at least two clocks each. Below that, the edge detector cannot see every revolution. They also assume the host never raises the read and write strobes in the same cycle. The stimulus drives the fan input as a square wave whose half-periods are tens of cycles or more. It sets all bus signals on the falling clock edge, one strobe at a time. Measured periods are swept across the low-byte rollover and into saturation, using a small tick divider and a narrowed counter.

// File: rtl/tach_pkg.sv
package tach_pkg;

    typedef enum logic [0:0] {
        MEAS_RUN   = 1'b0,
        MEAS_STALL = 1'b1
    } meas_state_t;

    localparam logic [7:0] IDX_CNT_LO  = 8'h10;
    localparam logic [7:0] IDX_CNT_HI  = 8'h11;
    localparam logic [7:0] IDX_BASE_HI = 8'h30;
    localparam logic [7:0] IDX_BASE_LO = 8'h31;

endpackage

// File: rtl/tach_sync_edge.sv
module tach_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tach_in,
    output logic rise
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= tach_in;
    end

    generate
        for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[i] <= 1'b0;
                else        sync_q[i] <= sync_q[i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[SYNC_STAGES-1];
    end

    assign rise = sync_q[SYNC_STAGES-1] & ~last_q;

    // R2: a revolution edge cannot repeat in back-to-back cycles
    assert_edge_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/tach_period.sv
module tach_period
    import tach_pkg::*;
#(
    parameter int TICK_DIV = 1388,
    parameter int CNT_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    output logic [CNT_W-1:0] result
);
    localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [DIV_W-1:0] div_q;
    logic             tick;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    meas_state_t      state_q, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    div_q <= '0;
        else if (tick) div_q <= '0;
        else           div_q <= div_q + DIV_W'(1);
    end
    assign tick = (div_q == DIV_W'(TICK_DIV - 1));

    assign cnt_inc = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + CNT_W'(tick);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MEAS_RUN;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            MEAS_RUN:   if (!rise && cnt_inc == CNT_MAX) state_nx = MEAS_STALL;
            MEAS_STALL: if (rise)                        state_nx = MEAS_RUN;
            default:    state_nx = MEAS_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            result <= '0;
        end else if (rise) begin
            result <= cnt_inc;
            cnt_q  <= '0;
        end else if (state_q == MEAS_RUN && cnt_inc == CNT_MAX) begin
            result <= CNT_MAX;
            cnt_q  <= CNT_MAX;
        end else begin
            cnt_q  <= cnt_inc;
        end
    end

    // R3: an edge restarts the running count
    assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> cnt_q == '0);

    // R2: without an edge the count moves by at most one
    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1)));

    // R4: while stalled the reported value stays at the maximum
    assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MEAS_STALL && !rise) |=> result == CNT_MAX);

endmodule

// File: rtl/tach_regs.sv
module tach_regs
    import tach_pkg::*;
#(
    parameter logic [15:0] BASE_RST = 16'h0480
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] bus_addr,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [7:0]  bus_wdata,
    input  logic [15:0] result,
    output logic [7:0]  bus_rdata
);
    logic [15:0] base_q;
    logic [7:0]  index_q;
    logic [7:0]  held_hi_q;
    logic        hit_idx, hit_dat;
    logic        lo_rd;
    logic [7:0]  sel_data;

    assign hit_idx = (bus_addr == base_q);
    assign hit_dat = (bus_addr == base_q + 16'd1);
    assign lo_rd   = bus_rd && hit_dat && (index_q == IDX_CNT_LO);

    always_comb begin
        unique case (index_q)
            IDX_CNT_LO:  sel_data = result[7:0];
            IDX_CNT_HI:  sel_data = held_hi_q;
            IDX_BASE_HI: sel_data = base_q[15:8];
            IDX_BASE_LO: sel_data = base_q[7:0];
            default:     sel_data = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q    <= BASE_RST;
            index_q   <= 8'h00;
            held_hi_q <= 8'h00;
            bus_rdata <= 8'h00;
        end else begin
            if (bus_rd && hit_idx)      bus_rdata <= index_q;
            else if (bus_rd && hit_dat) bus_rdata <= sel_data;
            else                        bus_rdata <= 8'h00;
            if (lo_rd) held_hi_q <= result[15:8];
            if (bus_wr && hit_idx) index_q <= bus_wdata;
            if (bus_wr && hit_dat) begin
                if (index_q == IDX_BASE_HI) base_q[15:8] <= bus_wdata;
                if (index_q == IDX_BASE_LO) base_q[7:0]  <= bus_wdata;
            end
        end
    end

    // R6: a low byte read captures the high half of the same sample
    assert_hold_on_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lo_rd |=> held_hi_q == $past(result[15:8]));

    // R7: the holding register changes only through a low byte read
    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_rd |=> $stable(held_hi_q));

    // R5: no read strobe means zero on the read bus next cycle
    assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> bus_rdata == 8'h00);

endmodule

// File: rtl/tach_monitor.sv
module tach_monitor #(
    parameter int          CLK_HZ   = 125_000_000,
    parameter int          TICK_HZ  = 90_000,
    parameter int          TICK_DIV = CLK_HZ / TICK_HZ,
    parameter int          CNT_W    = 16,
    parameter logic [15:0] BASE_RST = 16'h0480
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tach_in,
    input  logic [15:0] bus_addr,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata
);
    logic             rise;
    logic [CNT_W-1:0] result;
    logic [15:0]      result16;

    tach_sync_edge #(.SYNC_STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .tach_in(tach_in), .rise(rise)
    );

    tach_period #(.TICK_DIV(TICK_DIV), .CNT_W(CNT_W)) u_period (
        .clk(clk), .rst_n(rst_n), .rise(rise), .result(result)
    );

    assign result16 = 16'(result);

    tach_regs #(.BASE_RST(BASE_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .result(result16),
        .bus_rdata(bus_rdata)
    );

endmodule

// File: tb/sim_tach_monitor.sv
module sim_tach_monitor;
    localparam int DIV  = 4;
    localparam int CW   = 10;
    localparam int CMAX = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tach_in = 1'b0;
    logic [15:0] bus_addr = 16'h0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_wdata = 8'h0;
    logic [7:0]  bus_rdata;

    int n_tests = 0, n_fail = 0;
    int per = 0;
    bit done = 0;
    logic [15:0] base = 16'h0480;

    tach_monitor #(.TICK_DIV(DIV), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .tach_in(tach_in), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #4 clk = ~clk;

    initial begin
        forever begin
            if (per == 0) begin
                tach_in = 1'b0;
                @(negedge clk);
            end else begin
                int p;
                p = per;
                tach_in = 1'b1;
                repeat (p / 2) @(negedge clk);
                tach_in = 1'b0;
                repeat (p - p / 2) @(negedge clk);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] idx, output logic [7:0] d);
        bus_write(base, idx);
        bus_read(base + 16'd1, d);
    endtask

    task automatic reg_write(input logic [7:0] idx, input logic [7:0] v);
        bus_write(base, idx);
        bus_write(base + 16'd1, v);
    endtask

    task automatic settle(input int p);
        repeat (2000 + 3 * p + 50) @(negedge clk);
    endtask

    task automatic final_report;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            final_report();
        end
    end

    initial begin
        logic [7:0] d, lo, hi;
        int periods [6] = '{40, 100, 400, 1020, 1024, 2000};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(base, d);           chk("R1 index", d, 0);
        reg_read(8'h10, d);          chk("R1 low", d, 0);
        reg_read(8'h11, d);          chk("R1 high", d, 0);
        // R9 reset base
        reg_read(8'h30, d);          chk("R9 base hi", d, 8'h04);
        reg_read(8'h31, d);          chk("R9 base lo", d, 8'h80);

        // R2 sweep of periods, across the low byte rollover
        foreach (periods[i]) begin
            int e;
            per = periods[i];
            settle(per);
            e = per / DIV;
            reg_read(8'h10, lo);
            reg_read(8'h11, hi);
            chk("R2 low", lo, e & 8'hFF);
            chk("R2 high", hi, e >> 8);
        end

        // R3 short period after a long one replaces the value
        per = 40;
        settle(per);
        reg_read(8'h10, lo); reg_read(8'h11, hi);
        chk("R3 restart", {hi, lo}, 10);

        // R4 stall saturates and holds
        per = 0;
        repeat (2000 + CMAX * DIV + 200) @(negedge clk);
        reg_read(8'h10, lo); reg_read(8'h11, hi);
        chk("R4 sat", {hi, lo}, CMAX);
        repeat (1000) @(negedge clk);
        reg_read(8'h10, lo); reg_read(8'h11, hi);
        chk("R4 hold", {hi, lo}, CMAX);
        per = 40;
        settle(per);
        reg_read(8'h10, lo); reg_read(8'h11, hi);
        chk("R4 resume", {hi, lo}, 10);

        // R7 held high byte survives a result change
        per = 400;
        settle(per);
        reg_read(8'h10, lo);         chk("R6 low", lo, 100);
        per = 2000;
        settle(per);
        reg_read(8'h11, hi);         chk("R7 held", hi, 0);
        reg_read(8'h11, hi);         chk("R7 held again", hi, 0);
        reg_read(8'h10, lo);         chk("R6 low new", lo, 8'hF4);
        reg_read(8'h11, hi);         chk("R7 fresh", hi, 1);

        // R8 writes ignored, unimplemented reads zero
        reg_write(8'h10, 8'hAA);
        reg_read(8'h10, lo);         chk("R8 lo write ignored", lo, 8'hF4);
        reg_write(8'h11, 8'h55);
        reg_read(8'h11, hi);         chk("R8 hi write ignored", hi, 1);
        reg_read(8'h55, d);          chk("R8 unimpl 55", d, 0);
        reg_read(8'h00, d);          chk("R8 unimpl 00", d, 0);

        // R5 index readback and idle read bus
        bus_write(base, 8'h5A);
        bus_read(base, d);           chk("R5 index", d, 8'h5A);
        @(negedge clk);              chk("R5 idle", bus_rdata, 0);

        // R9 out-of-window and base reprogramming
        bus_read(base + 16'd2, d);   chk("R9 outside", d, 0);
        reg_write(8'h31, 8'h00);
        bus_read(16'h0480, d);       chk("R9 old base", d, 0);
        base = 16'h0400;
        bus_read(base, d);           chk("R9 new lo base", d, 8'h31);
        reg_write(8'h30, 8'h05);
        base = 16'h0500;
        bus_read(base, d);           chk("R9 new hi base", d, 8'h30);
        reg_read(8'h30, d);          chk("R9 base hi readback", d, 8'h05);
        reg_read(8'h10, lo);         chk("R9 count via new base", lo, 8'hF4);

        done = 1;
        final_report();
    end
endmodule